// File: doc/BRIEF.md
# Holding Torque Reference Selector

This block decides which current reference a pair of winding-current chopper comparators should compare against. A stepper drive needs full current while the rotor is moving, but far less to hold it in place. Every step command therefore opens a window of a programmable number of clock cycles during which the stepping reference is chosen. Once that window closes without a further step, the block switches to the lower holding reference, which saves power while the motor is at rest. When the hold feature is turned off, the stepping reference stays selected at all times.

The block also handles torque ripple in half-step operation. In that mode the translator alternates between one-phase-on and two-phase-on states, and the two-phase-on states give noticeably more torque. When compensation is enabled, the block requests a 70.7% scale on the chosen reference during two-phase-on states, which makes the torque of both kinds of state equal. Two-phase-on states are the odd translator state indices.

Both outputs are plain select bits for an external analog multiplexer and scaler. They are not a data stream, so the block has no valid/ready handshake and never stalls.

Top module: `hold_ref_select`

## Requirements
- R1: A cycle with `step_evt` high loads the timeout with `delay_cycles` = D. If D is nonzero, `use_hold` is 0 (stepping reference) for exactly the D clock cycles that follow that edge, provided `hold_en` stays 1.
- R2: Once D cycles have passed after the last step with no new step, `use_hold` becomes 1 (holding reference) and stays 1 until the next step.
- R3: A step that arrives while the timeout is still running restarts it from the current `delay_cycles` value.
- R4: While `hold_en` is 0, `use_hold` is 0 in every cycle. The timeout keeps running, so raising `hold_en` in the middle of a window still shows the stepping reference until that window expires.
- R5: While `rst_n` is low, the timeout is cleared. `use_hold` then equals `hold_en`.
- R6: A step with D = 0 leaves the timeout expired, so `use_hold` stays 1 when `hold_en` is 1.
- R7: `scale_down` is 1 (70.7% scale) exactly when `comp_en` = 1, `half_mode` = 1 and bit 0 of `state_idx` is 1 (an odd state, meaning two-phase-on). Otherwise it is 0 (100% scale).
- R8: When `half_mode` = 0 (full step), `comp_en` has no effect and `scale_down` is 0.
- R9: `scale_down` does not depend on the timeout or on `hold_en`. It applies to whichever reference is currently selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_evt | input | 1 | One-cycle step command |
| state_idx | input | STATE_W | Translator state index; odd values are two-phase-on |
| half_mode | input | 1 | 1 = half-step mode, 0 = full-step mode |
| hold_en | input | 1 | 1 = enable the switch to the holding reference |
| comp_en | input | 1 | 1 = enable torque-ripple compensation |
| delay_cycles | input | DLY_W | Length of the stepping window, in clock cycles |
| use_hold | output | 1 | 1 = holding reference, 0 = stepping reference |
| scale_down | output | 1 | 1 = scale the reference to 70.7%, 0 = 100% |

## Verification
The bench builds the block with a 6-bit delay width and a 3-bit state index. With those widths, random delays cover the whole range from 0 to 63, so zero-length windows, maximum-length windows and steps that land inside a running window all occur frequently within a few thousand cycles. The 3-bit state index covers all eight half-step states, so both parities are seen under every combination of mode and compensation enable, in both the stepping and the holding phase.

// File: rtl/hold_ref_pkg.sv
package hold_ref_pkg;
  typedef enum logic {
    REF_STEP = 1'b0,
    REF_HOLD = 1'b1
  } ref_sel_e;

  typedef enum logic {
    SCALE_FULL = 1'b0,
    SCALE_707  = 1'b1
  } scale_sel_e;
endpackage

// File: rtl/hold_ref_timeout.sv
module hold_ref_timeout #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_evt,
  input  logic [DLY_W-1:0] delay_cycles,
  output logic             expired
);
  logic [DLY_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (step_evt) begin
      remain_q <= delay_cycles;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expired = (remain_q == '0);

  // R3: a step always restarts the window from the current delay
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> remain_q == $past(delay_cycles));

  // R1: a running window counts down by one each idle cycle
  assert_countdown_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && remain_q != '0) |=> remain_q == $past(remain_q) - 1'b1);

  // R2: once expired, the state holds until a step arrives
  assert_stay_expired_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !step_evt) |=> expired);
endmodule

// File: rtl/hold_ref_scale.sv
module hold_ref_scale #(
  parameter int STATE_W = 3
) (
  input  logic [STATE_W-1:0] state_idx,
  input  logic               half_mode,
  input  logic               comp_en,
  output hold_ref_pkg::scale_sel_e scale_sel
);
  import hold_ref_pkg::*;

  logic two_phase_on;

  assign two_phase_on = state_idx[0];

  always_comb begin
    scale_sel = SCALE_FULL;
    if (comp_en && half_mode && two_phase_on) begin
      scale_sel = SCALE_707;
    end
  end
endmodule

// File: rtl/hold_ref_select.sv
module hold_ref_select #(
  parameter int DLY_W   = 8,
  parameter int STATE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_evt,
  input  logic [STATE_W-1:0] state_idx,
  input  logic               half_mode,
  input  logic               hold_en,
  input  logic               comp_en,
  input  logic [DLY_W-1:0]   delay_cycles,
  output logic               use_hold,
  output logic               scale_down
);
  import hold_ref_pkg::*;

  logic       expired;
  ref_sel_e   ref_sel;
  scale_sel_e scale_sel;

  hold_ref_timeout #(.DLY_W(DLY_W)) u_timeout (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_evt     (step_evt),
    .delay_cycles (delay_cycles),
    .expired      (expired)
  );

  hold_ref_scale #(.STATE_W(STATE_W)) u_scale (
    .state_idx (state_idx),
    .half_mode (half_mode),
    .comp_en   (comp_en),
    .scale_sel (scale_sel)
  );

  always_comb begin
    ref_sel = REF_STEP;
    if (hold_en && expired) begin
      ref_sel = REF_HOLD;
    end
  end

  assign use_hold   = (ref_sel == REF_HOLD);
  assign scale_down = (scale_sel == SCALE_707);

  // R1: a step with nonzero delay shows the stepping reference next cycle
  assert_step_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && delay_cycles != '0) |=> !use_hold);

  // R6: a step with zero delay keeps the holding reference while hold is kept on
  assert_zero_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && delay_cycles == '0 && hold_en) |=> (use_hold || !hold_en));

  // R8: full-step mode never requests scaling
  assert_full_no_scale_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !half_mode |-> !scale_down);
endmodule

// File: tb/hold_ref_select_test.sv
module hold_ref_select_test;
  localparam int DLY_W   = 6;
  localparam int STATE_W = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               step_evt = 1'b0;
  logic [STATE_W-1:0] state_idx = '0;
  logic               half_mode = 1'b0;
  logic               hold_en = 1'b0;
  logic               comp_en = 1'b0;
  logic [DLY_W-1:0]   delay_cycles = '0;
  logic               use_hold;
  logic               scale_down;

  int checks = 0;
  int errors = 0;
  int m_rem = 0;

  always #2 clk = ~clk;

  hold_ref_select #(.DLY_W(DLY_W), .STATE_W(STATE_W)) uut (
    .clk (clk), .rst_n (rst_n), .step_evt (step_evt), .state_idx (state_idx),
    .half_mode (half_mode), .hold_en (hold_en), .comp_en (comp_en),
    .delay_cycles (delay_cycles), .use_hold (use_hold), .scale_down (scale_down)
  );

  function automatic logic exp_hold(input logic hen, input int rem);
    return hen && (rem == 0);
  endfunction

  function automatic logic exp_scale(input logic cen, input logic half, input logic [STATE_W-1:0] st);
    return cen && half && st[0];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // drive one cycle at the falling edge, check, advance the model past the next rising edge
  task automatic tick(input logic stp, input logic [STATE_W-1:0] st, input logic half,
                      input logic hen, input logic cen, input logic [DLY_W-1:0] dly,
                      input string hreq, input string sreq);
    @(negedge clk);
    step_evt = stp; state_idx = st; half_mode = half;
    hold_en = hen; comp_en = cen; delay_cycles = dly;
    #1;
    check(hreq, use_hold, exp_hold(hen, m_rem));
    check(sreq, scale_down, exp_scale(cen, half, st));
    if (stp) m_rem = int'(dly);
    else if (m_rem != 0) m_rem--;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R5: reset clears the timeout; holding selected when hold enabled
    hold_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5", use_hold, 1'b1);
    hold_en = 1'b0;
    #1;
    check("R5", use_hold, 1'b0);
    rst_n = 1'b1;

    // R1, R2: window of 3 then holding
    tick(1, 3'd0, 0, 1, 0, 6'd3, "R1", "R8");
    repeat (3) tick(0, 3'd0, 0, 1, 0, 6'd3, "R1", "R8");
    repeat (3) tick(0, 3'd0, 0, 1, 0, 6'd9, "R2", "R8");

    // R3: retrigger inside a running window
    tick(1, 3'd2, 0, 1, 0, 6'd5, "R3", "R8");
    repeat (2) tick(0, 3'd2, 0, 1, 0, 6'd5, "R3", "R8");
    tick(1, 3'd2, 0, 1, 0, 6'd5, "R3", "R8");
    repeat (7) tick(0, 3'd2, 0, 1, 0, 6'd5, "R3", "R8");

    // R6: zero delay never leaves holding
    tick(1, 3'd4, 0, 1, 0, 6'd0, "R6", "R8");
    repeat (2) tick(0, 3'd4, 0, 1, 0, 6'd0, "R6", "R8");

    // R4: hold disabled, then enabled mid-window
    tick(1, 3'd1, 0, 0, 0, 6'd6, "R4", "R8");
    repeat (2) tick(0, 3'd1, 0, 0, 0, 6'd6, "R4", "R8");
    repeat (6) tick(0, 3'd1, 0, 1, 0, 6'd6, "R4", "R8");

    // R8: compensation ignored in full-step on odd states
    for (int s = 0; s < 8; s++) tick(0, 3'(s), 0, 1, 1, 6'd2, "R2", "R8");
    // R7: half-step compensation on every state, holding phase
    for (int s = 0; s < 8; s++) tick(0, 3'(s), 1, 1, 1, 6'd2, "R2", "R7");
    // R9: same scaling during the stepping phase
    tick(1, 3'd3, 1, 1, 1, 6'd20, "R1", "R9");
    for (int s = 0; s < 8; s++) tick(0, 3'(s), 1, 1, 1, 6'd20, "R1", "R9");
    tick(0, 3'd5, 1, 1, 0, 6'd20, "R1", "R7");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic stp;
      stp = ($urandom_range(0, 15) == 0);
      tick(stp, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
           6'($urandom_range(0, 63)), "R1/R2/R3 random", "R7/R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule